// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Threshold Flags

This block buffers 36-bit words in one direction between a producer and a consumer that share a clock. The depth is a parameter. A strap input is sampled while reset is held, and it fixes one of two read timings until the next reset.

In **standard** timing, a stored word reaches `rd_data` only when a read is requested. In **fall-through** timing, the oldest word is moved to `rd_data` without any request, and each read request then advances to the next word. In fall-through timing the output register holds one word in addition to the memory array, so the block holds `DEPTH + 1` words in total.

Two ready flags serve both timings. `rd_rdy` means "memory not empty" in standard timing and "a valid word is on `rd_data`" in fall-through timing. `wr_rdy` means "memory not full" in both timings. Two active-low threshold flags, `ae_n` and `af_n`, compare the fill level against offsets supplied from outside.

The output stage is a two-state machine:
- **OS_VACANT**: no valid word is held in the output register.
- **OS_LOADED**: a valid word is held there. This state is used only in fall-through timing.

Its transitions are:
- **load**: OS_VACANT to OS_LOADED, when memory holds a word.
- **advance**: OS_LOADED to OS_LOADED, on a read request while memory holds a word.
- **drain**: OS_LOADED to OS_VACANT, on a read request while memory is empty.
- **idle**: the state stays where it is. This covers every other case, including all of standard timing.

Top module: `dual_mode_fifo`

## Requirements
- R1: When `rst_n` is low, `mode_std` is captured: 1 selects standard timing and 0 selects fall-through timing. Changes on `mode_std` after reset has been released have no effect.
- R2: A clock edge with `rst_n` low does the following: both pointers return to entry 0, `rd_data` is cleared to all zeroes and the output stage becomes vacant. After release, `rd_rdy`=0, `wr_rdy`=1, `ae_n`=0 and `af_n`=1 (provided `af_off` < `DEPTH`).
- R3: In standard timing, a written word does not reach `rd_data` by itself. A read with `rd_rdy`=1 places the oldest word on `rd_data` after that clock edge. Words leave in the order they were written.
- R4: In fall-through timing, a word written to an empty FIFO appears on `rd_data` with `rd_rdy`=1 one edge after the edge that wrote it, with no read request. A read with `rd_rdy`=1 replaces it with the next word after that edge.
- R5: `rd_rdy` is high when memory holds at least one word (standard timing), or when the output register holds a valid word (fall-through timing).
- R6: `wr_rdy` is high while memory holds fewer than `DEPTH` words. In fall-through timing, `DEPTH + 1` words are therefore accepted before `wr_rdy` falls.
- R7: `ae_n` is 0 exactly when the stored count is less than or equal to `ae_off`. In fall-through timing, a word held in the output register counts as stored.
- R8: `af_n` is 0 exactly when (`DEPTH` minus the words in memory) is less than or equal to `af_off`.
- R9: A write while `wr_rdy`=0 is ignored. A read while `rd_rdy`=0 is ignored and leaves `rd_data` unchanged. No stored word is lost or duplicated.
- R10: A write and a read in the same cycle both take effect, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low master reset |
| mode_std | input | 1 | Timing strap, sampled during reset (1 = standard, 0 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Output register |
| rd_rdy | output | 1 | Empty-flag / output-ready flag, high when data is available |
| wr_rdy | output | 1 | Full-flag / input-ready flag, high when there is space |
| ae_off | input | 5 | Almost-empty offset (width $clog2(DEPTH+2)) |
| af_off | input | 5 | Almost-full offset (width $clog2(DEPTH+2)) |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The bench runs the same short burst in both timings, and the two runs tell the timings apart:
- In standard timing, `rd_data` stays zero until a read is made.
- In fall-through timing, the first word appears unasked.
- In fall-through timing the held word is counted, so the almost-empty flag differs between the two timings at the same fill level.

A fill-to-capacity run steps across the almost-full threshold one word at a time. It shows that standard timing stops at `DEPTH` words and fall-through timing at `DEPTH + 1`. It then sends a write into the full FIFO and drains every word, which exposes any lost, duplicated or reordered word. A run with reads and writes in the same cycle, and reads from an empty FIFO, separates correct simultaneous updates from ones that drop either side.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic {
        MODE_FWFT = 1'b0,
        MODE_STD  = 1'b1
    } fifo_mode_e;

    typedef enum logic {
        OS_VACANT = 1'b0,
        OS_LOADED = 1'b1
    } out_state_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_level.sv
module fifo_level #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] mem_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            mem_cnt <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
            unique case ({push, pop})
                2'b10:   mem_cnt <= mem_cnt + CW'(1);
                2'b01:   mem_cnt <= mem_cnt - CW'(1);
                default: mem_cnt <= mem_cnt;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (mem_cnt != CW'(DEPTH)));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (mem_cnt != '0));

    // R10
    balanced_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(mem_cnt));
endmodule

// File: rtl/fifo_outstage.sv
module fifo_outstage
    import fifo_pkg::*;
#(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_mode_e       mode,
    input  logic             rd_en,
    input  logic             mem_has,
    input  logic [WIDTH-1:0] mem_word,
    output logic             pop,
    output logic [WIDTH-1:0] data_q,
    output logic             out_ready,
    output logic             holding
);
    out_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OS_VACANT;
        else        state <= nxt;
    end

    // next state and pop decision
    always_comb begin
        nxt = state;
        pop = 1'b0;
        if (mode == MODE_STD) begin
            pop = rd_en && mem_has;
            nxt = OS_VACANT;
        end else begin
            unique case (state)
                OS_VACANT: begin
                    if (mem_has) begin
                        pop = 1'b1;
                        nxt = OS_LOADED;
                    end
                end
                OS_LOADED: begin
                    if (rd_en) begin
                        pop = mem_has;
                        nxt = mem_has ? OS_LOADED : OS_VACANT;
                    end
                end
                default: nxt = OS_VACANT;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)   data_q <= '0;
        else if (pop) data_q <= mem_word;
    end

    assign holding   = (state == OS_LOADED);
    assign out_ready = (mode == MODE_STD) ? mem_has : holding;

    // R3
    std_vacant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD) |=> (state == OS_VACANT));

    // R4
    fwft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FWFT && holding && !rd_en) |=> (holding && $stable(data_q)));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready && !mem_has) |=> $stable(data_q));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import fifo_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_std,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_rdy,
    output logic             wr_rdy,
    input  logic [CW-1:0]    ae_off,
    input  logic [CW-1:0]    af_off,
    output logic             ae_n,
    output logic             af_n
);
    fifo_mode_e       mode_q;
    logic             push, pop, holding, mem_has;
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    mem_cnt, stored, free_slots;
    logic [WIDTH-1:0] mem_word;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= fifo_mode_e'(mode_std);
    end

    assign mem_has = (mem_cnt != '0);
    assign wr_rdy  = (mem_cnt < CW'(DEPTH));
    assign push    = wr_en && wr_rdy;

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (mem_word)
    );

    fifo_level #(.DEPTH(DEPTH)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .wptr    (wptr),
        .rptr    (rptr),
        .mem_cnt (mem_cnt)
    );

    fifo_outstage #(.WIDTH(WIDTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .rd_en     (rd_en),
        .mem_has   (mem_has),
        .mem_word  (mem_word),
        .pop       (pop),
        .data_q    (rd_data),
        .out_ready (rd_rdy),
        .holding   (holding)
    );

    assign stored     = mem_cnt + CW'(holding);
    assign free_slots = CW'(DEPTH) - mem_cnt;
    assign ae_n       = !(stored <= ae_off);
    assign af_n       = !(free_slots <= af_off);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !rd_rdy));

    // R8
    full_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rdy |-> !af_n);

    // R7
    empty_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_rdy |-> (!ae_n || (mode_q == MODE_STD) == 1'b0));

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));
endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
    localparam int W  = 36;
    localparam int D  = 16;
    localparam int CW = $clog2(D + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_std = 1'b1;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rd_rdy, wr_rdy, ae_n, af_n;
    logic [CW-1:0] ae_off = CW'(2);
    logic [CW-1:0] af_off = CW'(3);

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_mode_fifo #(.WIDTH(W), .DEPTH(D)) u_dual_mode_fifo (
        .clk(clk), .rst_n(rst_n), .mode_std(mode_std),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_rdy(rd_rdy), .wr_rdy(wr_rdy), .ae_off(ae_off), .af_off(af_off),
        .ae_n(ae_n), .af_n(af_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; mode_std = strap; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mode_std = ~strap;   // R1: later changes must be ignored
    endtask

    task automatic write_burst(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = W'(base + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic read_one();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic test_reset_state();
        do_reset(1'b1);
        check("R2 rd_data", rd_data, 0);
        check("R2 rd_rdy", rd_rdy, 0);
        check("R2 wr_rdy", wr_rdy, 1);
        check("R2 ae_n", ae_n, 0);
        check("R2 af_n", af_n, 1);
    endtask

    task automatic test_standard();
        do_reset(1'b1);
        write_burst(32'h11, 3);
        check("R3 no fall-through", rd_data, 0);
        check("R5 std rd_rdy", rd_rdy, 1);
        check("R7 ae_n stored 3", ae_n, 1);
        read_one();
        check("R3 first word", rd_data, 32'h11);
        check("R7 ae_n stored 2", ae_n, 0);
        read_one();
        check("R3 second word", rd_data, 32'h12);
        read_one();
        check("R3 third word", rd_data, 32'h13);
        check("R5 std empty", rd_rdy, 0);
        read_one();
        check("R9 empty read ignored", rd_data, 32'h13);
        check("R1 mode held", rd_rdy, 0);
    endtask

    task automatic test_fwft();
        do_reset(1'b0);
        write_burst(32'hA0, 1);
        @(negedge clk);
        check("R4 fall-through data", rd_data, 32'hA0);
        check("R4 R5 output ready", rd_rdy, 1);
        write_burst(32'hA1, 2);
        check("R4 held without read", rd_data, 32'hA0);
        check("R7 held word counted", ae_n, 1);
        read_one();
        check("R4 advance 1", rd_data, 32'hA1);
        read_one();
        check("R4 advance 2", rd_data, 32'hA2);
        check("R5 still ready", rd_rdy, 1);
        read_one();
        check("R5 drained", rd_rdy, 0);
        check("R7 empty ae_n", ae_n, 0);
    endtask

    task automatic test_std_full();
        do_reset(1'b1);
        write_burst(100, D - 4);
        check("R8 free 4 af_n", af_n, 1);
        write_burst(100 + D - 4, 1);
        check("R8 free 3 af_n", af_n, 0);
        write_burst(100 + D - 3, 3);
        check("R6 std full", wr_rdy, 0);
        write_burst(999, 1);
        check("R9 full write ignored", wr_rdy, 0);
        for (int i = 0; i < D; i++) begin
            read_one();
            check("R9 R3 drain order", rd_data, 64'(100 + i));
        end
        check("R9 no extra word", rd_rdy, 0);
    endtask

    task automatic test_fwft_full();
        do_reset(1'b0);
        write_burst(200, D + 1);
        check("R6 fwft full at DEPTH+1", wr_rdy, 0);
        check("R8 fwft af_n", af_n, 0);
        write_burst(999, 1);
        for (int i = 0; i <= D; i++) begin
            check("R6 R9 fwft order", rd_data, 64'(200 + i));
            read_one();
        end
        check("R9 fwft no extra", rd_rdy, 0);
    endtask

    task automatic test_simultaneous();
        do_reset(1'b1);
        write_burst(32'h50, 2);
        wr_en = 1'b1; wr_data = 32'h52; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read side", rd_data, 32'h50);
        check("R10 level kept", ae_n, 0);
        read_one();
        check("R10 second", rd_data, 32'h51);
        read_one();
        check("R10 write side", rd_data, 32'h52);
        check("R10 empty after", rd_rdy, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        test_reset_state();
        test_standard();
        test_fwft();
        test_std_full();
        test_fwft_full();
        test_simultaneous();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule